// File: doc/BRIEF.md
# Clock Multiplier Change Sequencer

This block decides, cycle by cycle, which ratio the system clock should have relative to the oscillator clock it runs on. Software programs a multiplier code through a simple write port (address, data, strobe). The block keeps the code, returns it on a readback port, and presents the selected ratio as a numerator/denominator pair. The analog loop, the clock switch and the clock generation itself are left to other logic.

When a new non-zero code is written, the loop has to settle. The block then holds the reported ratio at half the oscillator frequency for a fixed lock interval of `LOCK_CYCLES` oscillator cycles, 131072 by default, and raises a busy flag for that interval. After the interval the ratio moves to the new multiplier. Code 0 selects bypass: the ratio is half the oscillator frequency and no lock interval is run.

Top module: `pll_ratio_sequencer`

## Requirements
- R1: After a synchronous active-low reset, the stored code is 0, `lock_busy` is low and the ratio is 1/2 (`ratio_num`=1, `ratio_den`=2).
- R2: A write with `wr_en` high and `wr_addr` equal to `CFG_ADDR` stores `wr_data[CFG_W-1:0]`, and `cfg_rdata` shows the new value from the next cycle on.
- R3: A write that changes the stored code to a non-zero value raises `lock_busy` in the cycle after the write edge. `lock_busy` then stays high for exactly `LOCK_CYCLES` cycles.
- R4: While `lock_busy` is high, the ratio is 1/2 (numerator 1, denominator 2).
- R5: With `lock_busy` low and a non-zero code C, the ratio is C/2 (`ratio_num`=C, `ratio_den`=2). Code 4 gives twice the oscillator frequency and code 8 gives four times.
- R6: Writing code 0 selects bypass. The ratio is 1/2 and no lock interval starts. A lock interval already running is ended at once.
- R7: Writing the code that is already stored starts no new lock interval and does not lengthen one that is running.
- R8: A write of a different non-zero code during a lock interval restarts the full `LOCK_CYCLES` count. When that count ends, the ratio is the newest code.
- R9: Writes to any other address leave the stored code, `lock_busy` and the ratio unchanged. Data bits at or above `CFG_W` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data, low CFG_W bits hold the multiplier code |
| cfg_rdata | output | CFG_W | Readback of the stored code |
| lock_busy | output | 1 | High while the lock interval runs |
| ratio_num | output | RATIO_W | Numerator of system clock / oscillator ratio |
| ratio_den | output | RATIO_W | Denominator of system clock / oscillator ratio |

## Verification
The bench measures the busy pulse edge to edge. A counter off by one, or a busy flag that starts one cycle late, shows up as a length other than `LOCK_CYCLES`. A retarget partway through a lock must extend the pulse to a full interval counted from the second write. A design that kept the old count would end early, and one that kept the old target would land on the wrong ratio. Rewriting the same code and writing to a foreign address must leave the busy flag low and the ratio steady. Writing 0 during a lock must drop straight to bypass, where a wrong design would keep reporting busy.

// File: rtl/pll_seq_pkg.sv
// Shared definitions for the clock multiplier change sequencer.
package pll_seq_pkg;
    localparam int unsigned RATIO_W = 8;

    typedef struct packed {
        logic [RATIO_W-1:0] num;
        logic [RATIO_W-1:0] den;
    } ratio_t;

    // Ratio reported during lock and in bypass: oscillator / 2.
    localparam ratio_t HALF_RATIO = '{num: RATIO_W'(1), den: RATIO_W'(2)};
endpackage

// File: rtl/pll_cfg_reg.sv
// Multiplier code register. Decodes writes, stores the code and flags
// whether a write starts a lock interval (new non-zero code) or cancels
// one (new code 0). Assumes a single write port with no read strobe.
module pll_cfg_reg #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned CFG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              start_lock,
    output logic              cancel_lock
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);

    logic             hit;
    logic [CFG_W-1:0] new_code;
    logic             changed;
    logic             unused_hi_bits;

    // Decode the write and compare against the stored code.
    always_comb begin
        hit         = wr_en && (wr_addr == HIT_ADDR);
        new_code    = wr_data[CFG_W-1:0];
        changed     = new_code != cfg_q;
        start_lock  = hit && changed && (new_code != '0);
        cancel_lock = hit && changed && (new_code == '0);
    end

    assign unused_hi_bits = ^wr_data;

    // Store the code on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n)   cfg_q <= '0;
        else if (hit) cfg_q <= new_code;
    end

    // R9: a write elsewhere leaves the code alone.
    assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != HIT_ADDR) |=> $stable(cfg_q));
    // R2: an addressed write lands in the register.
    assert_code_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg_q == $past(new_code)));
endmodule

// File: rtl/pll_lock_timer.sv
// Lock interval timer. A start pulse loads the full count and raises busy
// on the next cycle; busy lasts exactly LOCK_CYCLES cycles. A cancel pulse
// clears it at once. Assumes start and cancel are never high together.
module pll_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_lock,
    input  logic cancel_lock,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Load, count down and retire the lock interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (cancel_lock) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start_lock) begin
            busy   <= 1'b1;
            remain <= LOAD_VAL;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // R3: busy follows a start on the next cycle.
    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_lock |=> (busy && remain == LOAD_VAL));
    // R3: busy only ends on an exhausted count or a cancel.
    assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(remain) == '0 || $past(cancel_lock)));
    // R6: a cancel leaves the timer idle.
    assert_cancel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_lock |=> !busy);
    // R3: count stays inside the interval.
    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= LOAD_VAL);
endmodule

// File: rtl/pll_ratio_select.sv
// Output ratio selection. Reports oscillator/2 during lock or bypass,
// otherwise code/2. Assumes CFG_W does not exceed RATIO_W.
module pll_ratio_select #(
    parameter int unsigned CFG_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          busy,
    input  logic [CFG_W-1:0]              cfg_q,
    output logic [pll_seq_pkg::RATIO_W-1:0] ratio_num,
    output logic [pll_seq_pkg::RATIO_W-1:0] ratio_den
);
    import pll_seq_pkg::*;

    ratio_t sel;

    // Choose between the fallback and the programmed multiplier.
    always_comb begin
        if (busy || cfg_q == '0) begin
            sel = HALF_RATIO;
        end else begin
            sel.num = RATIO_W'(cfg_q);
            sel.den = RATIO_W'(2);
        end
    end

    assign ratio_num = sel.num;
    assign ratio_den = sel.den;

    // R4: fallback ratio throughout a lock interval.
    assert_fallback_in_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ratio_num == RATIO_W'(1) && ratio_den == RATIO_W'(2)));
    // R6: bypass code never reports a multiplied ratio.
    assert_bypass_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |-> (ratio_num == RATIO_W'(1)));
endmodule

// File: rtl/pll_ratio_sequencer.sv
// Top of the clock multiplier change sequencer. Runs on the oscillator
// clock, holds the multiplier code, times the lock interval after a change
// and reports the system clock ratio. Assumes synchronous active-low reset.
module pll_ratio_sequencer #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CFG_W       = 4,
    parameter int unsigned CFG_ADDR    = 0,
    parameter int unsigned LOCK_CYCLES = 131072
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [CFG_W-1:0]                cfg_rdata,
    output logic                            lock_busy,
    output logic [pll_seq_pkg::RATIO_W-1:0] ratio_num,
    output logic [pll_seq_pkg::RATIO_W-1:0] ratio_den
);
    logic [CFG_W-1:0] cfg_q;
    logic             start_lock;
    logic             cancel_lock;

    pll_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_q(cfg_q), .start_lock(start_lock),
        .cancel_lock(cancel_lock)
    );

    pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_lock(start_lock),
        .cancel_lock(cancel_lock), .busy(lock_busy)
    );

    pll_ratio_select #(.CFG_W(CFG_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .busy(lock_busy), .cfg_q(cfg_q),
        .ratio_num(ratio_num), .ratio_den(ratio_den)
    );

    assign cfg_rdata = cfg_q;

    // R7: rewriting the stored code leaves an idle timer idle.
    assert_same_code_no_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CFG_ADDR) && wr_data[CFG_W-1:0] == cfg_q && !lock_busy)
        |=> !lock_busy);
endmodule

// File: tb/test_pll_ratio_sequencer.sv
module test_pll_ratio_sequencer;
    localparam int unsigned LOCK = 40;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 16;
    localparam int unsigned CW = 4;
    localparam int unsigned RW = pll_seq_pkg::RATIO_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] cfg_rdata;
    logic lock_busy;
    logic [RW-1:0] ratio_num, ratio_den;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    pll_ratio_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CFG_W(CW), .CFG_ADDR(0),
                          .LOCK_CYCLES(LOCK)) i_pll_ratio_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_rdata(cfg_rdata), .lock_busy(lock_busy),
        .ratio_num(ratio_num), .ratio_den(ratio_den)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_ratio(input string req, input int num, input int den);
        check(req, int'(ratio_num), num);
        check(req, int'(ratio_den), den);
    endtask

    // Drive one write at the falling edge; return at the next falling edge.
    task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // Count consecutive falling edges with busy high, starting now.
    task automatic busy_length(output int len);
        len = 0;
        for (int i = 0; i < int'(LOCK) + 20; i++) begin
            if (!lock_busy) break;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code", int'(cfg_rdata), 0);
        check("R1 busy", int'(lock_busy), 0);
        check_ratio("R1 ratio", 1, 2);
    endtask

    task automatic t_basic_lock(input int code);
        int len;
        write_reg('0, DW'(code));
        check("R2 readback", int'(cfg_rdata), code);
        check("R3 busy rises", int'(lock_busy), 1);
        check_ratio("R4 fallback", 1, 2);
        busy_length(len);
        check("R3 busy length", len, int'(LOCK));
        check_ratio("R5 final ratio", code, 2);
    endtask

    task automatic t_same_code;
        write_reg('0, 16'h0008);
        check("R7 no lock on rewrite", int'(lock_busy), 0);
        check_ratio("R7 ratio steady", 8, 2);
    endtask

    task automatic t_retarget;
        int len;
        write_reg('0, 16'h0004);
        idle(10);
        write_reg('0, 16'h0004);  // same code mid-lock: no extension
        write_reg('0, 16'h0006);
        busy_length(len);
        check("R8 restarted length", len, int'(LOCK));
        check_ratio("R8 new target", 6, 2);
    endtask

    task automatic t_cancel;
        write_reg('0, 16'h000A);
        idle(5);
        check("R4 mid-lock", int'(lock_busy), 1);
        write_reg('0, 16'h0000);
        check("R6 cancel busy", int'(lock_busy), 0);
        check_ratio("R6 bypass ratio", 1, 2);
        check("R6 readback", int'(cfg_rdata), 0);
    endtask

    task automatic t_foreign;
        int len;
        write_reg('0, 16'h0004);
        busy_length(len);
        write_reg(4'h3, 16'h000C);
        check("R9 foreign code", int'(cfg_rdata), 4);
        check("R9 foreign busy", int'(lock_busy), 0);
        check_ratio("R9 foreign ratio", 4, 2);
        write_reg('0, 16'hFFF4);  // upper bits ignored: same code 4
        check("R9 upper bits code", int'(cfg_rdata), 4);
        check("R9 upper bits no lock", int'(lock_busy), 0);
    endtask

    task automatic t_bypass_idle;
        write_reg('0, 16'h0000);
        check("R6 bypass no lock", int'(lock_busy), 0);
        check_ratio("R6 bypass idle ratio", 1, 2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_basic_lock(4);
        t_basic_lock(8);
        t_same_code();
        t_retarget();
        t_cancel();
        t_foreign();
        t_bypass_idle();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule